// File: doc/BRIEF.md
# Registered Sum-of-Products State Slice

This block is a small sequential slice of programmable logic. It has a fixed product-term plane that feeds three output cells. Two cells hold the state bits of a two-bit machine, and each keeps its bit in a set/clear storage element. The third cell produces the machine's Mealy output flag. The stored bits are routed back into the product-term plane, so the next state and the flag both depend on the current state and the two data inputs.

Every cell has its own path select and its own output enable. With the select low, the cell's pin carries the combinational value, which is the value its storage will load at the next clock edge. With the select high, the pin carries the stored value. When the enable is low, the pin is forced to 0. The state bits are also brought out on a separate port that is not gated, so an observer can follow the machine whatever the pin settings are.

Top module: `pal_seq_slice`

## Requirements
- R1: With `rst` high at a rising clock edge, both state bits and the stored flag clear to 0 at that edge. The inputs and the pin controls have no effect on this.
- R2: The high state bit (`state_out[1]`) is set by `!in_a & in_b & state_out[0]` and cleared by `state_out[1]`. At each rising edge it loads 1 when set alone is true, loads 0 when clear is true (clear wins over set), and otherwise holds.
- R3: The low state bit (`state_out[0]`) is set by `!in_a & !in_b` and cleared by `in_a | in_b`, with the same set/clear/hold rule.
- R4: The flag value is `state_out[1] & !state_out[0] & in_a & !in_b`. It is formed combinationally from the current state and the current inputs.
- R5: A cell with its select bit at 0 and its enable at 1 drives its combinational value on its pin. For a state cell that value is the next-state value from R2/R3. For the flag cell it is the R4 value. Pin and control bit positions: bit 0 is the flag cell, bit 1 the low state cell, bit 2 the high state cell.
- R6: A cell with its select bit at 1 and its enable at 1 drives its stored value on its pin. For a state cell this is the current state bit. For the flag cell it is the R4 value captured at the previous rising edge.
- R7: A cell whose enable bit is 0 drives 0 on its pin, whatever its select bit and its values are.
- R8: The state sequence does not depend on `cell_sel` or `cell_oe`. Feedback always comes from the stored bits.
- R9: `state_out` always shows both stored state bits, whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | 1 | First data input of the machine |
| in_b | input | 1 | Second data input of the machine |
| cell_sel | input | 3 | Per-cell path select: 1 = stored, 0 = combinational |
| cell_oe | input | 3 | Per-cell pin enable: 0 forces the pin to 0 |
| pin_out | output | 3 | Cell pins: [0] flag, [1] low state, [2] high state |
| state_out | output | 2 | Stored state bits: [1] high, [0] low |

## Verification
The bench walks the machine through every reachable state and applies each input pair from each state. In one of these moves the high bit sets, and in the very next cycle it clears itself through its own feedback. A design that took the feedback from the pin instead of from storage would stall or corrupt that sequence whenever a pin is disabled or set to the combinational path. The flag is checked in both of its forms. The combinational form must react to the inputs within the same cycle. The stored form must lag by exactly one edge, so a design that swapped the two paths or added latency shows a mismatch. Random enables and selects are applied on every cycle, including during reset, and they catch a pin that leaks a value while disabled and a reset that depends on the pin controls.

// File: rtl/pal_sm_pkg.sv
package pal_sm_pkg;

    localparam int NCELL     = 3;
    localparam int NSTATE    = 2;
    localparam int CELL_FLAG = 0;
    localparam int CELL_LO   = 1;
    localparam int CELL_HI   = 2;

    typedef struct packed {
        logic set;
        logic clr;
    } sr_drive_t;

    // Set/clear storage update: clear dominates, neither holds.
    function automatic logic sr_step(input logic cur, input sr_drive_t d);
        if (d.clr)      return 1'b0;
        else if (d.set) return 1'b1;
        else            return cur;
    endfunction

    // A plain data value expressed as a set/clear pair.
    function automatic sr_drive_t as_data(input logic v);
        sr_drive_t r;
        r.set = v;
        r.clr = ~v;
        return r;
    endfunction

endpackage

// File: rtl/pal_and_or_plane.sv
module pal_and_or_plane
    import pal_sm_pkg::*;
(
    input  logic      in_a,
    input  logic      in_b,
    input  logic      fb_hi,
    input  logic      fb_lo,
    output sr_drive_t drv_hi,
    output sr_drive_t drv_lo,
    output logic      flag_sum
);

    always_comb begin
        drv_hi.set = ~in_a & in_b & fb_lo;
        drv_hi.clr = fb_hi;
        drv_lo.set = ~in_a & ~in_b;
        drv_lo.clr = in_a | in_b;
        flag_sum   = fb_hi & ~fb_lo & in_a & ~in_b;
    end

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
    import pal_sm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sr_drive_t drv,
    input  logic      sel_reg,
    input  logic      oe,
    output logic      fb,
    output logic      pin
);

    logic stored;
    logic comb_val;

    assign comb_val = sr_step(stored, drv);

    always_ff @(posedge clk) begin
        if (rst) stored <= 1'b0;
        else     stored <= comb_val;
    end

    assign fb  = stored;
    assign pin = oe ? (sel_reg ? stored : comb_val) : 1'b0;

endmodule

// File: rtl/pal_seq_slice.sv
module pal_seq_slice
    import pal_sm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_a,
    input  logic              in_b,
    input  logic [NCELL-1:0]  cell_sel,
    input  logic [NCELL-1:0]  cell_oe,
    output logic [NCELL-1:0]  pin_out,
    output logic [NSTATE-1:0] state_out
);

    sr_drive_t [NCELL-1:0] drv;
    logic      [NCELL-1:0] fb;
    sr_drive_t             drv_hi;
    sr_drive_t             drv_lo;
    logic                  flag_sum;

    pal_and_or_plane u_plane (
        .in_a     (in_a),
        .in_b     (in_b),
        .fb_hi    (fb[CELL_HI]),
        .fb_lo    (fb[CELL_LO]),
        .drv_hi   (drv_hi),
        .drv_lo   (drv_lo),
        .flag_sum (flag_sum)
    );

    always_comb begin
        drv[CELL_HI]   = drv_hi;
        drv[CELL_LO]   = drv_lo;
        drv[CELL_FLAG] = as_data(flag_sum);
    end

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        pal_macrocell u_cell (
            .clk     (clk),
            .rst     (rst),
            .drv     (drv[i]),
            .sel_reg (cell_sel[i]),
            .oe      (cell_oe[i]),
            .fb      (fb[i]),
            .pin     (pin_out[i])
        );
    end

    assign state_out = {fb[CELL_HI], fb[CELL_LO]};

endmodule

// File: rtl/pal_seq_slice_chk.sv
module pal_seq_slice_chk
    import pal_sm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_a,
    input logic              in_b,
    input logic [NCELL-1:0]  cell_sel,
    input logic [NCELL-1:0]  cell_oe,
    input logic [NCELL-1:0]  pin_out,
    input logic [NSTATE-1:0] state_out
);

    // R1: reset clears the state
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (state_out == 2'b00));

    // R2: the high bit clears itself one edge after it is seen set
    a_r2_hi_self_clear: assert property (@(posedge clk) disable iff (rst)
        state_out[1] |=> !state_out[1]);

    // R2: set term with the bit clear loads 1
    a_r2_hi_set: assert property (@(posedge clk) disable iff (rst)
        (!in_a && in_b && state_out[0] && !state_out[1]) |=> state_out[1]);

    // R3: any input high clears the low bit
    a_r3_lo_clear: assert property (@(posedge clk) disable iff (rst)
        (in_a || in_b) |=> !state_out[0]);

    // R3: both inputs low set the low bit
    a_r3_lo_set: assert property (@(posedge clk) disable iff (rst)
        (!in_a && !in_b) |=> state_out[0]);

    // R4: combinational flag pin high only in its single qualifying condition
    a_r4_flag_cond: assert property (@(posedge clk) disable iff (rst)
        (cell_oe[CELL_FLAG] && !cell_sel[CELL_FLAG] && pin_out[CELL_FLAG])
            |-> (state_out == 2'b10 && in_a && !in_b));

    // R7: disabled pins stay low
    a_r7_oe_gates: assert property (@(posedge clk)
        ((~cell_oe & pin_out) == '0));

    // R9: registered enabled state pins mirror the visible state
    a_r9_state_pin: assert property (@(posedge clk)
        (cell_oe[CELL_HI] && cell_sel[CELL_HI]) |-> (pin_out[CELL_HI] == state_out[1]));

endmodule

bind pal_seq_slice pal_seq_slice_chk u_chk (.*);

// File: tb/pal_seq_slice_tb.sv
module pal_seq_slice_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_a, in_b;
    logic [2:0] cell_sel, cell_oe;
    logic [2:0] pin_out;
    logic [1:0] state_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // model state
    logic m_hi, m_lo, m_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    pal_seq_slice u_dut (
        .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b),
        .cell_sel(cell_sel), .cell_oe(cell_oe),
        .pin_out(pin_out), .state_out(state_out)
    );

    function automatic logic nxt(input logic cur, input logic s, input logic c);
        return c ? 1'b0 : (s ? 1'b1 : cur);
    endfunction

    function automatic logic next_hi(input logic a, input logic b, input logic hi, input logic lo);
        return nxt(hi, !a && b && lo, hi);
    endfunction

    function automatic logic next_lo(input logic a, input logic b, input logic lo);
        return nxt(lo, !a && !b, a || b);
    endfunction

    function automatic logic flag_now(input logic a, input logic b, input logic hi, input logic lo);
        return hi && !lo && a && !b;
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: check state, apply inputs, check pins, clock, update model.
    task automatic step(input logic r, input logic a, input logic b,
                        input logic [2:0] s, input logic [2:0] e, input string req);
        logic [2:0] comb, regv, exp_pin;
        logic nh, nl, fz;
        @(negedge clk);
        check({"R8/R9 state ", req}, {2'b0, state_out}, {2'b0, m_hi, m_lo});
        rst = r; in_a = a; in_b = b; cell_sel = s; cell_oe = e;
        #1;
        nh = next_hi(a, b, m_hi, m_lo);
        nl = next_lo(a, b, m_lo);
        fz = flag_now(a, b, m_hi, m_lo);
        comb = {nh, nl, fz};
        regv = {m_hi, m_lo, m_flag};
        for (int i = 0; i < 3; i++)
            exp_pin[i] = e[i] ? (s[i] ? regv[i] : comb[i]) : 1'b0;
        check({"R4/R5/R6/R7 pins ", req}, {1'b0, pin_out}, {1'b0, exp_pin});
        @(posedge clk);
        if (r) begin
            m_hi = 0; m_lo = 0; m_flag = 0;
        end else begin
            m_hi = nh; m_lo = nl; m_flag = fz;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; in_a = 0; in_b = 0; cell_sel = 3'b111; cell_oe = 3'b111;
        m_hi = 0; m_lo = 0; m_flag = 0;
        // R1: reset under inputs that would set the low bit
        @(posedge clk);
        step(1, 0, 0, 3'b111, 3'b111, "R1 reset");
        step(1, 0, 0, 3'b000, 3'b000, "R1 reset pins off");
        @(negedge clk);
        check("R1 state after reset", {2'b0, state_out}, 4'h0);
        check("R1 stored pins after reset", {1'b0, pin_out & 3'b101}, 4'h0);

        // Directed walk: 00 -> 01 -> 10 with flag, then 00
        step(0, 0, 0, 3'b111, 3'b111, "R3 set lo");
        step(0, 0, 1, 3'b000, 3'b111, "R2 set hi / R3 clr lo comb pins");
        step(0, 1, 0, 3'b000, 3'b111, "R4 flag comb in state 10");
        step(0, 0, 0, 3'b111, 3'b111, "R6 flag stored one edge later");
        step(0, 0, 0, 3'b111, 3'b000, "R7 all disabled");
        step(0, 0, 1, 3'b111, 3'b111, "R2 hi set from 01");
        step(0, 0, 1, 3'b101, 3'b111, "R2 hi self clear");
        step(0, 1, 1, 3'b000, 3'b010, "R3 clr both inputs");
        step(0, 0, 0, 3'b010, 3'b110, "R3 set again");
        step(0, 0, 1, 3'b000, 3'b000, "R8 set hi with pins disabled");
        step(0, 1, 0, 3'b000, 3'b001, "R4 flag with others disabled");
        step(1, 0, 0, 3'b001, 3'b001, "R1 reset with flag stored");

        // Random: inputs, selects, enables, occasional reset
        for (int k = 0; k < N_RANDOM; k++) begin
            logic [31:0] rv;
            rv = $urandom;
            step(rv[12:7] == 6'd0, rv[0], rv[1], rv[4:2], rv[13] ? 3'b111 : rv[6:5] ^ {rv[8], 2'b00},
                 "R2/R3/R5/R6/R7/R8 random");
        end

        @(negedge clk);
        check("R9 final state", {2'b0, state_out}, {2'b0, m_hi, m_lo});
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule